// File: doc/BRIEF.md
# Ethernet MII Receive Frame Check Sequence Checker

This block validates the trailing CRC-32 of Ethernet frames received over a 4-bit media-independent interface. One nibble arrives per clock while a valid strobe is high. The stream starts with the first byte after the start-of-frame delimiter and runs through the last FCS byte. The checker keeps a running CRC-32 that advances four bits per clock. When the valid strobe drops, it issues a one-cycle frame-done pulse together with exactly one of a good or a bad verdict.

Two checking modes are selected by a static mode input, which is changed only between frames. In residual mode the whole stream, FCS included, goes through the CRC, and the frame is good when the register ends at a fixed constant. In compare mode an eight-nibble delay line holds the FCS back from the CRC. Only data reaches the CRC, and at the end the held nibbles are compared with the complement of the register.

The controller has two states. ST_IDLE waits for the strobe. The transition idle-to-receive fires on the first valid nibble and presets the CRC. ST_RECV accumulates nibbles. The transition receive-to-idle fires when the strobe drops and launches the verdict.

Top module: `mii_fcs_check`

## Requirements
- R1: After reset, frame_done_o, crc_ok_o and crc_err_o are all low and stay low while rx_dv_i is low.
- R2: With cmp_mode_i = 0 (residual mode), a frame whose last four bytes are the bitwise complement of the CRC-32 (polynomial 0x04C11DB7, preset 0xFFFFFFFF) of the preceding bytes produces crc_ok_o. The bytes are fed least significant bit first, the FCS is sent least significant byte first, each byte arrives low nibble first, and bit 0 of rx_nib_i is the earliest bit.
- R3: In residual mode, a frame with any single corrupted nibble produces crc_err_o.
- R4: With cmp_mode_i = 1 (compare mode), a correctly formed frame produces crc_ok_o.
- R5: In compare mode, a corruption in either the data or the FCS nibbles produces crc_err_o.
- R6: A frame with an odd number of nibbles produces crc_err_o, even if its content would otherwise match.
- R7: A frame of fewer than eight nibbles produces crc_err_o in both modes. An eight-nibble frame holding only the FCS of empty data (all zero) produces crc_ok_o in both modes.
- R8: The verdict is registered. frame_done_o and exactly one of crc_ok_o or crc_err_o are high for exactly one clock, in the cycle after the first cycle in which rx_dv_i is low. They are never high at any other time.
- R9: A new frame may start in the cycle right after the valid strobe drops. The previous frame's verdict then appears in the same cycle as the new frame's first nibble, and the new frame is judged correctly.
- R10: The CRC is preset at the start of every frame, so a good frame that follows a bad one is judged good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_mode_i | input | 1 | 0 selects residual mode, 1 selects compare mode; static during a frame |
| rx_dv_i | input | 1 | Receive data valid |
| rx_nib_i | input | 4 | Receive nibble, bit 0 earliest in time |
| frame_done_o | output | 1 | One-cycle pulse marking the end of a frame |
| crc_ok_o | output | 1 | One-cycle pulse: frame check sequence correct |
| crc_err_o | output | 1 | One-cycle pulse: frame check sequence wrong, odd length or short |

## Verification
Two functions can fall in the same cycle. One is the registered verdict of a frame that has just ended. The other is the absorption of the first nibble of the next frame, which must restart the CRC from its preset. The bench provokes this with a single idle cycle between a corrupted frame and a clean copy of it. In the cycle where the second frame's first nibble is driven, it requires the error pulse for the first frame. It then requires a good verdict for the second frame, which shows that the preset was not disturbed by the leftover state of the bad frame. This is run in both modes.

// File: rtl/mii_fcs_pkg.sv
package mii_fcs_pkg;

    // Reflected (least-significant-bit-first) form of the CRC-32 generator
    localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC32_PRESET    = 32'hFFFFFFFF;
    // Register content after data plus correct FCS, no final inversion
    localparam logic [31:0] CRC32_RESIDUE   = 32'hDEBB20E3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } fcs_state_e;

endpackage

// File: rtl/mii_fcs_crc_step.sv
// Combinational CRC advance by NIB_W input bits, bit 0 consumed first.
module mii_fcs_crc_step #(
    parameter int          CRC_W = 32,
    parameter int          NIB_W = 4,
    parameter logic [31:0] POLY  = mii_fcs_pkg::CRC32_POLY_REFL
) (
    input  logic [CRC_W-1:0] state_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic [CRC_W-1:0] next_o
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = state_i;
        fb  = 1'b0;
        for (int b = 0; b < NIB_W; b++) begin
            fb  = acc[0] ^ nib_i[b];
            acc = (acc >> 1) ^ ({CRC_W{fb}} & POLY[CRC_W-1:0]);
        end
        next_o = acc;
    end
endmodule

// File: rtl/mii_fcs_delay.sv
// Nibble delay line: holds the most recent DEPTH nibbles of the stream.
module mii_fcs_delay #(
    parameter int NIB_W = 4,
    parameter int DEPTH = 8,
    localparam int WORD_W = NIB_W * DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [NIB_W-1:0]  oldest_o,
    output logic [WORD_W-1:0] word_o
);
    logic [NIB_W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else if (shift_i) begin
                if (g == 0) begin
                    stg[g] <= nib_i;
                end else begin
                    stg[g] <= stg[(g == 0) ? 0 : g-1];
                end
            end
        end
        // earliest held nibble lands in the least significant position
        assign word_o[g*NIB_W +: NIB_W] = stg[DEPTH-1-g];
    end

    assign oldest_o = stg[DEPTH-1];
endmodule

// File: rtl/mii_fcs_ctrl.sv
// Frame state machine, length tracking and registered verdict.
module mii_fcs_ctrl #(
    parameter int FILL_N = 8,
    localparam int FILL_W = $clog2(FILL_N + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dv_i,
    input  logic match_i,
    output logic idle_o,
    output logic full_o,
    output logic frame_done_o,
    output logic crc_ok_o,
    output logic crc_err_o
);
    import mii_fcs_pkg::*;

    fcs_state_e        state_q, state_d;
    logic [FILL_W-1:0] fill_q;
    logic              odd_q;
    logic              end_w;
    logic              good_w;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (dv_i)  state_d = ST_RECV;
            ST_RECV: if (!dv_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // nibble fill (saturating at FILL_N) and length parity of current frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            odd_q  <= 1'b0;
        end else if (dv_i) begin
            if (state_q == ST_IDLE) begin
                fill_q <= FILL_W'(1);
                odd_q  <= 1'b1;
            end else begin
                if (fill_q != FILL_W'(FILL_N)) begin
                    fill_q <= fill_q + 1'b1;
                end
                odd_q <= ~odd_q;
            end
        end
    end

    assign idle_o = (state_q == ST_IDLE);
    assign full_o = (state_q == ST_RECV) && (fill_q == FILL_W'(FILL_N));
    assign end_w  = (state_q == ST_RECV) && !dv_i;
    assign good_w = match_i && !odd_q && (fill_q == FILL_W'(FILL_N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_done_o <= 1'b0;
            crc_ok_o     <= 1'b0;
            crc_err_o    <= 1'b0;
        end else begin
            frame_done_o <= end_w;
            crc_ok_o     <= end_w && good_w;
            crc_err_o    <= end_w && !good_w;
        end
    end
endmodule

// File: rtl/mii_fcs_check.sv
module mii_fcs_check #(
    parameter int          NIB_W   = 4,
    parameter int          CRC_W   = 32,
    parameter logic [31:0] POLY    = mii_fcs_pkg::CRC32_POLY_REFL,
    parameter logic [31:0] PRESET  = mii_fcs_pkg::CRC32_PRESET,
    parameter logic [31:0] RESIDUE = mii_fcs_pkg::CRC32_RESIDUE,
    localparam int FCS_NIBS = CRC_W / NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_mode_i,
    input  logic             rx_dv_i,
    input  logic [NIB_W-1:0] rx_nib_i,
    output logic             frame_done_o,
    output logic             crc_ok_o,
    output logic             crc_err_o
);
    logic [CRC_W-1:0] crc_q, crc_base, crc_next, crc_d;
    logic [NIB_W-1:0] dly_oldest, step_nib;
    logic [CRC_W-1:0] dly_word;
    logic             in_idle, dly_full, feed, match;

    mii_fcs_delay #(.NIB_W(NIB_W), .DEPTH(FCS_NIBS)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (rx_dv_i),
        .nib_i    (rx_nib_i),
        .oldest_o (dly_oldest),
        .word_o   (dly_word)
    );

    mii_fcs_ctrl #(.FILL_N(FCS_NIBS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dv_i         (rx_dv_i),
        .match_i      (match),
        .idle_o       (in_idle),
        .full_o       (dly_full),
        .frame_done_o (frame_done_o),
        .crc_ok_o     (crc_ok_o),
        .crc_err_o    (crc_err_o)
    );

    // compare mode feeds the nibble leaving the delay line, once it is full
    assign step_nib = cmp_mode_i ? dly_oldest : rx_nib_i;
    assign feed     = rx_dv_i && (!cmp_mode_i || dly_full);
    assign crc_base = in_idle ? PRESET[CRC_W-1:0] : crc_q;

    mii_fcs_crc_step #(.CRC_W(CRC_W), .NIB_W(NIB_W), .POLY(POLY)) u_step (
        .state_i (crc_base),
        .nib_i   (step_nib),
        .next_o  (crc_next)
    );

    assign crc_d = feed ? crc_next : crc_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= PRESET[CRC_W-1:0];
        end else if (rx_dv_i) begin
            crc_q <= crc_d;
        end
    end

    assign match = cmp_mode_i ? (crc_q == ~dly_word)
                              : (crc_q == RESIDUE[CRC_W-1:0]);
endmodule

// File: rtl/mii_fcs_check_sva.sv
module mii_fcs_check_sva (
    input logic clk,
    input logic rst_n,
    input logic rx_dv_i,
    input logic frame_done_o,
    input logic crc_ok_o,
    input logic crc_err_o
);
    logic       prev_dv_q;
    logic [3:0] run_q;
    logic       odd_q;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_dv_q <= 1'b0;
            run_q     <= '0;
            odd_q     <= 1'b0;
        end else begin
            prev_dv_q <= rx_dv_i;
            if (rx_dv_i) begin
                if (!prev_dv_q) begin
                    run_q <= 4'd1;
                    odd_q <= 1'b1;
                end else begin
                    if (run_q < 4'd8) run_q <= run_q + 4'd1;
                    odd_q <= ~odd_q;
                end
            end
        end
    end

    assign fall = prev_dv_q && !rx_dv_i;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> ($countones({crc_ok_o, crc_err_o}) == 1)); // R8
    AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done_o |-> (!crc_ok_o && !crc_err_o)); // R8
    AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> frame_done_o); // R8
    AST_DONE_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> $past(fall)); // R8
    AST_SHORT_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && (run_q < 4'd8)) |=> crc_err_o); // R7
    AST_ODD_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && odd_q) |=> crc_err_o); // R6
endmodule

bind mii_fcs_check mii_fcs_check_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_dv_i      (rx_dv_i),
    .frame_done_o (frame_done_o),
    .crc_ok_o     (crc_ok_o),
    .crc_err_o    (crc_err_o)
);

// File: tb/mii_fcs_check_tb_top.sv
`timescale 1ns/1ps
module mii_fcs_check_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_mode = 1'b0;
    logic       rx_dv = 1'b0;
    logic [3:0] rx_nib = '0;
    logic       frame_done, crc_ok, crc_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] fbuf [0:127];
    int         flen = 0;

    always #4 clk = ~clk;

    mii_fcs_check dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_mode_i   (cmp_mode),
        .rx_dv_i      (rx_dv),
        .rx_nib_i     (rx_nib),
        .frame_done_o (frame_done),
        .crc_ok_o     (crc_ok),
        .crc_err_o    (crc_err)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference CRC register after n bytes of fbuf, reflected form
    function automatic logic [31:0] ref_reg(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ fbuf[i][b]) c = (c >> 1) ^ 32'hEDB88320;
                else                   c = c >> 1;
            end
        end
        return c;
    endfunction

    task automatic build(input int nbytes, input int seed);
        logic [31:0] f;
        for (int i = 0; i < nbytes; i++) fbuf[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
        f = ~ref_reg(nbytes);
        for (int i = 0; i < 4; i++) fbuf[nbytes + i] = f[8*i +: 8];
        flen = nbytes + 4;
    endtask

    function automatic logic [3:0] nib_at(input int k);
        return k[0] ? fbuf[k >> 1][7:4] : fbuf[k >> 1][3:0];
    endfunction

    task automatic send_nibs(input int first, input int n, input int flip);
        for (int k = first; k < n; k++) begin
            @(negedge clk);
            rx_dv  = 1'b1;
            rx_nib = nib_at(k) ^ ((k == flip) ? 4'h1 : 4'h0);
        end
    endtask

    task automatic end_and_judge(input bit exp_ok, input string req);
        @(negedge clk);
        rx_dv = 1'b0;
        @(negedge clk);
        chk({frame_done, crc_ok, crc_err} == {1'b1, exp_ok, !exp_ok}, req,
            "verdict {done,ok,err}", {29'd0, frame_done, crc_ok, crc_err},
            {29'd0, 1'b1, exp_ok, !exp_ok});
        @(negedge clk);
        chk({frame_done, crc_ok, crc_err} == 3'b000, "R8", "pulse width",
            {29'd0, frame_done, crc_ok, crc_err}, 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) begin
            @(negedge clk);
            chk({frame_done, crc_ok, crc_err} == 3'b000, "R1", "idle outputs",
                {29'd0, frame_done, crc_ok, crc_err}, 32'd0);
        end
    endtask

    task automatic t_residual;
        cmp_mode = 1'b0;
        build(20, 1);
        send_nibs(0, 2 * flen, -1);
        end_and_judge(1'b1, "R2");
        send_nibs(0, 2 * flen, 9);
        end_and_judge(1'b0, "R3");
        send_nibs(0, 2 * flen, 2 * flen - 1);
        end_and_judge(1'b0, "R3");
        build(60, 4);
        send_nibs(0, 2 * flen, -1);
        end_and_judge(1'b1, "R2");
    endtask

    task automatic t_compare;
        cmp_mode = 1'b1;
        build(46, 2);
        send_nibs(0, 2 * flen, -1);
        end_and_judge(1'b1, "R4");
        send_nibs(0, 2 * flen, 3);
        end_and_judge(1'b0, "R5");
        send_nibs(0, 2 * flen, 2 * flen - 2);
        end_and_judge(1'b0, "R5");
        build(1, 3);
        send_nibs(0, 2 * flen, -1);
        end_and_judge(1'b1, "R4");
    endtask

    task automatic t_odd;
        for (int m = 0; m < 2; m++) begin
            cmp_mode = m[0];
            build(12, 5);
            fbuf[flen] = 8'h00;
            send_nibs(0, 2 * flen + 1, -1);
            end_and_judge(1'b0, "R6");
        end
    endtask

    task automatic t_short;
        for (int m = 0; m < 2; m++) begin
            cmp_mode = m[0];
            build(0, 0);
            chk({fbuf[3], fbuf[2], fbuf[1], fbuf[0]} == 32'h0, "R7", "empty FCS model",
                {fbuf[3], fbuf[2], fbuf[1], fbuf[0]}, 32'h0);
            send_nibs(0, 8, -1);
            end_and_judge(1'b1, "R7");
            send_nibs(0, 6, -1);
            end_and_judge(1'b0, "R7");
            send_nibs(0, 1, -1);
            end_and_judge(1'b0, "R7");
        end
    endtask

    task automatic t_back_to_back;
        for (int m = 0; m < 2; m++) begin
            cmp_mode = m[0];
            build(30, 7 + m);
            send_nibs(0, 2 * flen, 20);
            @(negedge clk);
            rx_dv = 1'b0;
            @(negedge clk);
            chk({frame_done, crc_ok, crc_err} == 3'b101, "R9", "verdict beside next start",
                {29'd0, frame_done, crc_ok, crc_err}, 32'd5);
            rx_dv  = 1'b1;
            rx_nib = nib_at(0);
            send_nibs(1, 2 * flen, -1);
            end_and_judge(1'b1, "R10");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_residual();
        t_compare();
        t_odd();
        t_short();
        t_back_to_back();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule